// File: doc/BRIEF.md
# Peripheral Module Gating Controller

This block decides, for each of a set of peripheral modules, whether the module receives a clock, whether its function runs, and whether the CPU may touch its registers. Each module is governed by three control bits. The first is a disable bit held in a central gating bank, which gives the strong shutdown: the clock is removed and register access is blocked. The second is an idle-disable bit, also in the bank, which stops the module only while the system idle input is high. The third is a functional enable bit held in the module's own control register, which gives the weak shutdown: the function stops, but the register stays readable and writable.

The CPU reaches the gating bank and every module's control register over a simple register bus. The address map is fixed. Word 0 holds the module disable bits and word 1 holds the idle-disable bits, with bit i of each belonging to module i. Word 2+i is the control register of module i, and bit 0 of that register is its functional enable. Some modules have no functional enable. For those modules, bit 0 is not implemented, and the function simply follows the clock. The gating bank itself is never gated.

Top module: `pgc_top`

## Requirements
- R1: After reset both bank words are zero, every clk_en and acc_ok bit is high, every module control register is zero, and so fn_en is high only for modules without a functional enable bit.
- R2: Writing 1 to bit i of bank word 0 drives clk_en[i], acc_ok[i] and fn_en[i] low from the cycle after the write, whatever idle is, and they stay low until the bit is cleared.
- R3: When idle is high and bit i of bank word 1 is set, clk_en[i] and fn_en[i] are low. When idle is high and that bit is clear, module i stays clocked.
- R4: A write to the control register at word 2+i while acc_ok[i] is low leaves that register unchanged.
- R5: A read of word 2+i while acc_ok[i] is low returns zero on bus_rdata with bus_rinval high, one cycle after the read.
- R6: With module i clocked, clearing bit 0 of its control register drops fn_en[i] while clk_en[i] stays high, and the register can still be written and read back.
- R7: For a module without a functional enable, bit 0 of its control register always reads 0, and fn_en equals clk_en.
- R8: Both bank words can be written and read back, with bus_rinval low, at all times, including while idle is high and every module is disabled.
- R9: Read data and bus_rinval are registered and appear in the cycle after bus_rd. A read of a clocked module returns the stored value with bus_rinval low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle | input | 1 | System idle indication |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_rd |
| bus_rinval | output | 1 | Read data invalid (target module gated) |
| clk_en | output | NUM_MOD | Per-module clock enable |
| fn_en | output | NUM_MOD | Per-module function enable |
| acc_ok | output | NUM_MOD | Per-module register access valid |

## Verification
The bench builds the block with its defaults: four modules, an 8-bit data path, a 4-bit address, and an enable mask of 0111, so the top module has no functional enable bit. That mix places modules with and without an enable bit side by side. It lets one walk of the table combine a strong disable, an idle disable and a cleared function enable on different modules at once. It also covers the unimplemented bit 0 on the last module.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    // Fixed register word map
    localparam int BANK_DIS_ADDR = 0;   // bit i: module i clock disable
    localparam int BANK_IDL_ADDR = 1;   // bit i: module i disable while idle
    localparam int MOD_BASE      = 2;   // word MOD_BASE+i: module i control
    localparam int FN_EN_BIT     = 0;   // functional enable inside control word
endpackage

// File: rtl/pgc_gate_bank.sv
module pgc_gate_bank
    import pgc_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_MOD-1:0] dis_o,
    output logic [NUM_MOD-1:0] idis_o
);
    typedef struct packed {
        logic [NUM_MOD-1:0] dis;
        logic [NUM_MOD-1:0] idis;
    } bank_t;

    bank_t st_d, st_q;

    // The bank has no gating of its own: writes always land
    always_comb begin
        st_d = st_q;
        if (wr && addr == ADDR_W'(BANK_DIS_ADDR)) st_d.dis  = wdata[NUM_MOD-1:0];
        if (wr && addr == ADDR_W'(BANK_IDL_ADDR)) st_d.idis = wdata[NUM_MOD-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dis_o  = st_q.dis;
    assign idis_o = st_q.idis;
endmodule

// File: rtl/pgc_mod_slot.sv
module pgc_mod_slot
    import pgc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit HAS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              clk_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              fn_en_o
);
    localparam logic [DATA_W-1:0] EN_BIT    = DATA_W'(1) << FN_EN_BIT;
    localparam logic [DATA_W-1:0] IMPL_MASK = HAS_EN ? '1 : ~EN_BIT;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } slot_t;

    slot_t st_d, st_q;

    // A gated module has no clock, so its register cannot take a write
    always_comb begin
        st_d = st_q;
        if (wr_hit && clk_en) st_d.ctrl = wdata & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

    generate
        if (HAS_EN) begin : g_en
            assign fn_en_o = clk_en & st_q.ctrl[FN_EN_BIT];
        end else begin : g_noen
            assign fn_en_o = clk_en;
        end
    endgenerate
endmodule

// File: rtl/pgc_rd_port.sv
module pgc_rd_port
    import pgc_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_MOD-1:0]        dis,
    input  logic [NUM_MOD-1:0]        idis,
    input  logic [NUM_MOD*DATA_W-1:0] ctrl_flat,
    input  logic [NUM_MOD-1:0]        acc_ok,
    output logic [DATA_W-1:0]         rdata,
    output logic                      rinval
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              inval;
    } rd_t;

    rd_t st_d, st_q;
    logic [DATA_W-1:0] sel_val;
    logic              sel_gated;

    always_comb begin
        sel_val   = '0;
        sel_gated = 1'b0;
        if (addr == ADDR_W'(BANK_DIS_ADDR)) sel_val = DATA_W'(dis);
        if (addr == ADDR_W'(BANK_IDL_ADDR)) sel_val = DATA_W'(idis);
        for (int i = 0; i < NUM_MOD; i++) begin
            if (addr == ADDR_W'(MOD_BASE + i)) begin
                sel_val   = ctrl_flat[i*DATA_W +: DATA_W];
                sel_gated = ~acc_ok[i];
            end
        end
        st_d.data  = (rd && !sel_gated) ? sel_val : '0;
        st_d.inval = rd && sel_gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.data;
    assign rinval = st_q.inval;
endmodule

// File: rtl/pgc_top.sv
module pgc_top
    import pgc_pkg::*;
#(
    parameter int                 NUM_MOD = 4,
    parameter int                 ADDR_W  = 4,
    parameter int                 DATA_W  = 8,
    parameter logic [NUM_MOD-1:0] HAS_EN  = 4'b0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rinval,
    output logic [NUM_MOD-1:0] clk_en,
    output logic [NUM_MOD-1:0] fn_en,
    output logic [NUM_MOD-1:0] acc_ok
);
    localparam int CTRL_W = NUM_MOD * DATA_W;

    logic [NUM_MOD-1:0] dis, idis;
    logic [CTRL_W-1:0]  ctrl_flat;

    pgc_gate_bank #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .dis_o  (dis),
        .idis_o (idis)
    );

    // Strong disable wins; idle disable applies only while idle is high
    always_comb begin
        clk_en = ~dis & ~(idis & {NUM_MOD{idle}});
        acc_ok = clk_en;
    end

    generate
        for (genvar i = 0; i < NUM_MOD; i++) begin : g_slot
            pgc_mod_slot #(.DATA_W(DATA_W), .HAS_EN(HAS_EN[i])) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (bus_wr && bus_addr == ADDR_W'(MOD_BASE + i)),
                .clk_en  (clk_en[i]),
                .wdata   (bus_wdata),
                .ctrl_o  (ctrl_flat[i*DATA_W +: DATA_W]),
                .fn_en_o (fn_en[i])
            );
        end
    endgenerate

    pgc_rd_port #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .dis       (dis),
        .idis      (idis),
        .ctrl_flat (ctrl_flat),
        .acc_ok    (acc_ok),
        .rdata     (bus_rdata),
        .rinval    (bus_rinval)
    );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
    import pgc_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      idle,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      bus_rinval,
    input logic [NUM_MOD-1:0]        clk_en,
    input logic [NUM_MOD-1:0]        fn_en,
    input logic [NUM_MOD-1:0]        acc_ok,
    input logic [NUM_MOD*DATA_W-1:0] ctrl_flat
);
    // Reads of the bank words are never flagged
    assert_bank_read_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == ADDR_W'(BANK_DIS_ADDR) || bus_addr == ADDR_W'(BANK_IDL_ADDR))
        |=> !bus_rinval);

    generate
        for (genvar i = 0; i < NUM_MOD; i++) begin : g_chk
            assert_dis_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr && bus_addr == ADDR_W'(BANK_DIS_ADDR) && bus_wdata[i]
                |=> !clk_en[i] && !acc_ok[i] && !fn_en[i]);

            assert_fn_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
                fn_en[i] |-> clk_en[i]);

            assert_idle_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == ADDR_W'(BANK_IDL_ADDR) && bus_wdata[i]) ##1 idle
                |-> !clk_en[i]);

            assert_gated_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr && bus_addr == ADDR_W'(MOD_BASE + i) && !acc_ok[i]
                |=> $stable(ctrl_flat[i*DATA_W +: DATA_W]));

            assert_gated_read_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rd && bus_addr == ADDR_W'(MOD_BASE + i) && !acc_ok[i]
                |=> bus_rinval && bus_rdata == '0);
        end
    endgenerate
endmodule

bind pgc_top pgc_checker #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rinval (bus_rinval),
    .clk_en     (clk_en),
    .fn_en      (fn_en),
    .acc_ok     (acc_ok),
    .ctrl_flat  (ctrl_flat)
);

// File: tb/tb_pgc_top.sv
`timescale 1ns/1ps
module tb_pgc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rinval;
    logic [3:0] clk_en, fn_en, acc_ok;

    int runs = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    pgc_top dut (
        .clk(clk), .rst_n(rst_n), .idle(idle), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rinval(bus_rinval),
        .clk_en(clk_en), .fn_en(fn_en), .acc_ok(acc_ok)
    );

    typedef struct packed {
        logic [3:0] addr;
        logic [7:0] data;
        logic       idl;
        logic [3:0] exp_clk;
        logic [3:0] exp_fn;
    } vec_t;

    // Module 3 has no functional enable, so its fn_en follows clk_en
    localparam vec_t TBL [8] = '{
        '{4'd2, 8'h01, 1'b0, 4'hF, 4'b1001},  // R6: m0 function on
        '{4'd3, 8'h01, 1'b0, 4'hF, 4'b1011},  // R6: m1 function on
        '{4'd1, 8'h05, 1'b0, 4'hF, 4'b1011},  // R3: idle-disable m0,m2, not idle
        '{4'd1, 8'h05, 1'b1, 4'b1010, 4'b1010},  // R3: idle now high
        '{4'd0, 8'h08, 1'b1, 4'b0010, 4'b0010},  // R2: strong disable m3 in idle
        '{4'd0, 8'h08, 1'b0, 4'b0111, 4'b0011},  // R2: strong disable, not idle
        '{4'd0, 8'h00, 1'b0, 4'hF, 4'b1011},  // R2: released
        '{4'd2, 8'h00, 1'b0, 4'hF, 4'b1010}   // R6: m0 function off, still clocked
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d, output logic inv);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; inv = bus_rinval;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd_d;
        logic       rd_i;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 clk_en", 32'(clk_en), 32'hF);
        chk("R1 acc_ok", 32'(acc_ok), 32'hF);
        chk("R1 fn_en",  32'(fn_en),  32'h8);
        rst_n = 1'b1;
        bus_read(4'd0, rd_d, rd_i);
        chk("R1 dis word", 32'(rd_d), 32'h0);
        bus_read(4'd4, rd_d, rd_i);
        chk("R1 m2 ctrl", 32'(rd_d), 32'h0);

        // Table walk
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            idle = TBL[k].idl;
            bus_write(TBL[k].addr, TBL[k].data);
            chk($sformatf("table row %0d clk_en (R2/R3/R6)", k), 32'(clk_en), 32'(TBL[k].exp_clk));
            chk($sformatf("table row %0d fn_en (R2/R3/R6)", k),  32'(fn_en),  32'(TBL[k].exp_fn));
        end

        // R6: m0 register still readable with function off
        bus_read(4'd2, rd_d, rd_i);
        chk("R6 m0 readback", 32'(rd_d), 32'h0);
        chk("R6 m0 rinval", 32'(rd_i), 32'h0);

        // R8: bank always reachable, idle high and everything disabled
        idle = 1'b1;
        bus_write(4'd0, 8'h0F);
        bus_write(4'd1, 8'h0F);
        chk("R2 all gated", 32'(acc_ok), 32'h0);
        bus_read(4'd0, rd_d, rd_i);
        chk("R8 dis word", 32'(rd_d), 32'h0F);
        chk("R8 dis rinval", 32'(rd_i), 32'h0);
        bus_read(4'd1, rd_d, rd_i);
        chk("R8 idis word", 32'(rd_d), 32'h0F);

        // R4/R5: write and read while m1 gated
        bus_write(4'd3, 8'hA4);
        bus_read(4'd3, rd_d, rd_i);
        chk("R5 gated data", 32'(rd_d), 32'h0);
        chk("R5 gated rinval", 32'(rd_i), 32'h1);

        idle = 1'b0;
        bus_write(4'd0, 8'h00);
        bus_read(4'd3, rd_d, rd_i);
        chk("R4 write dropped", 32'(rd_d), 32'h01);
        chk("R9 rinval low", 32'(rd_i), 32'h0);

        // R6/R9: clocked module writable, value appears next cycle
        bus_write(4'd3, 8'hA4);
        chk("R6 m1 fn off", 32'(fn_en[1]), 32'h0);
        chk("R6 m1 clocked", 32'(clk_en[1]), 32'h1);
        @(negedge clk);
        bus_addr = 4'd3; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk("R9 registered data", 32'(bus_rdata), 32'hA4);

        // R7: module without enable bit
        bus_write(4'd5, 8'hFF);
        bus_read(4'd5, rd_d, rd_i);
        chk("R7 bit0 not kept", 32'(rd_d), 32'hFE);
        chk("R7 fn follows clk", 32'(fn_en[3]), 32'(clk_en[3]));
        bus_write(4'd0, 8'h08);
        chk("R7 fn off with clk", 32'(fn_en[3]), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule